// File: doc/BRIEF.md
# Serial-Loaded DAC Register Front End

This block is the digital slave-side front end of a voltage-output converter that is loaded over a three-wire serial link. A host frames each 16-bit word with an active-low frame strobe, sends it MSB first and presents each bit on the falling serial clock edge. The block collects the word in a 16-bit shift register. It then moves the code field into a DAC register, either when the frame ends or later under a separate active-low load strobe. The level of the load strobe at the start of the frame picks which of the two happens.

The same shift register also drives the serial output. With no readback in progress, the serial output carries the written stream delayed by one word, so that several devices can be chained. With readback requested, it returns the DAC register contents with zero padding. An active-low clear input raises a clamp flag, which tells the analog stage to hold its output at the ground reference. A power-down input raises a power-down flag. Neither input touches any register. The converter, the amplifier and the pad drivers are outside the block.

All serial and control inputs must already be synchronous to `clk`. The block compares each input with its value at the previous clock edge. It acts on an input edge at the first rising `clk` edge that sees the new level, and the registered outputs show the result immediately after that edge. The code bus is a level, not a stream, so there is no handshake at the block's edge.

Top module: `sdac_frontend`

## Requirements
- R1: After `rst_n` is released, `dac_code`, `out_clamp`, `pwr_down` and `sdo` are all 0.
- R2: While `sync_n` is low, each falling `sclk` edge shifts `sdin` into bit 0 of the 16-bit shift register. Existing bits move toward bit 15, so the first bit sent ends in bit 15. The falling edge of `sync_n` restarts the bit count.
- R3: The code field is word bits 13..0 when RES=14, and word bits 13..2 when RES=12. Bits 15..14, and bits 1..0 when RES=12, are ignored. Coding is straight binary.
- R4: If `ldac_n` is low at the falling edge of `sync_n`, the DAC register loads the code field on the rising edge of `sync_n`. With `ldac_n` held low, every complete frame updates `dac_code`.
- R5: If `ldac_n` is high at the falling edge of `sync_n`, the rising edge of `sync_n` leaves `dac_code` unchanged. The code is loaded at the next falling edge of `ldac_n` after that. A new falling edge of `sync_n` cancels a load that has not yet happened.
- R6: A frame with fewer than 16 falling `sclk` edges loads nothing. With more than 16 edges, the last 16 bits received form the word.
- R7: A falling edge of `rben_n` arms readback. The next falling `sclk` edge copies the DAC register into the shift register: the code sits in the position given in R3, and bits 15..14 (and bits 1..0 when RES=12) are 0. The following falling edges shift this word out on `sdo`, MSB first. A frame in which readback took place never loads the DAC register.
- R8: `sdo` is always bit 15 of the shift register. In a frame longer than 16 bits, the bit sent on edge k appears on `sdo` after edge k+15.
- R9: A falling edge of `clr_n` sets `out_clamp` and changes neither register. `out_clamp` is released once `clr_n` is high while `ldac_n` is low. It is released immediately if `ldac_n` is already low, and otherwise at the next `ldac_n` low pulse.
- R10: `pwr_down` follows `pd` one clock later, and `pd` has no effect on `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data in, MSB first |
| sync_n | input | 1 | Active-low frame strobe |
| ldac_n | input | 1 | Active-low load strobe |
| rben_n | input | 1 | Active-low readback request |
| clr_n | input | 1 | Active-low clear of the output level |
| pd | input | 1 | Power-down request |
| sdo | output | 1 | Serial data out (chained stream or readback) |
| dac_code | output | RES | DAC register contents |
| out_clamp | output | 1 | Hold the analog output at ground reference |
| pwr_down | output | 1 | Power-down flag to the analog stage |

## Verification
Random words are sent with a random load mode. This separates an immediate load at frame end from a deferred load, and a field taken from the wrong bits shows up across many codes. Words with the top bits set show whether the ignored bits leak into the code. Short frames of random length show whether a partial frame loads anything. A 32-bit frame checks that the chained output is delayed by exactly one word and that the last 16 bits are the ones kept. Readback and clear sequences check the zero padding and that the registers are left unchanged, and clear is exercised both with the load strobe held low and with it pulsed.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int CTL_W  = 5;
  localparam int I_SCLK = 0;
  localparam int I_SYNC = 1;
  localparam int I_LDAC = 2;
  localparam int I_RBEN = 3;
  localparam int I_CLR  = 4;
  localparam logic [CTL_W-1:0] CTL_IDLE = 5'b11110;
endpackage

// File: rtl/sdac_sampler.sv
module sdac_sampler #(
  parameter int W = 5,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= lvl;
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int RES = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_fall,
  input  logic           sync_fall,
  input  logic           sync_low,
  input  logic           rben_fall,
  input  logic           sdin,
  input  logic [RES-1:0] dac_q,
  output logic [RES-1:0] shift_code,
  output logic           frame_full,
  output logic           rb_frame,
  output logic           sdo
);
  localparam int PAD_LO = WORD_W - 2 - RES;

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;
  logic              rb_load;
  logic [WORD_W-1:0] rb_word;

  generate
    if (PAD_LO == 0) begin : g_full
      assign rb_word = {2'b00, dac_q};
    end else begin : g_padded
      assign rb_word = {2'b00, dac_q, {PAD_LO{1'b0}}};
    end
  endgenerate

  assign rb_load    = sclk_fall && armed_q;
  assign shift_code = shift_q[WORD_W-3 -: RES];
  assign frame_full = (cnt_q == CNT_W'(WORD_W));
  assign sdo        = shift_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      rb_frame <= 1'b0;
    end else begin
      if (sync_fall) begin
        cnt_q    <= '0;
        rb_frame <= 1'b0;
      end
      if (rb_load) begin
        shift_q  <= rb_word;
        rb_frame <= 1'b1;
        armed_q  <= 1'b0;
      end else begin
        if (rben_fall) armed_q <= 1'b1;
        if (sclk_fall && sync_low) begin
          shift_q <= {shift_q[WORD_W-2:0], sdin};
          if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7: a readback load always presents zero MSBs
  a_r7_rb_zero_msbs: assert property (@(posedge clk) disable iff (!rst_n)
    rb_load |=> (shift_q[WORD_W-1:WORD_W-2] == 2'b00));
  // R6: bit counter saturates at one word
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));
  // R8: serial output mirrors the register MSB after each shift
  a_r8_sdo_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && sync_low && !rb_load) |=> (sdo == $past(shift_q[WORD_W-2])));
endmodule

// File: rtl/sdac_dacreg.sv
module sdac_dacreg #(
  parameter int RES = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_fall,
  input  logic           sync_rise,
  input  logic           ldac_n,
  input  logic           ldac_fall,
  input  logic           clr_n,
  input  logic           clr_fall,
  input  logic           frame_full,
  input  logic           rb_frame,
  input  logic [RES-1:0] code_in,
  output logic [RES-1:0] dac_q,
  output logic           clamp_q
);
  logic ldac_cap_q;
  logic pend_q;
  logic frame_ok;

  assign frame_ok = sync_rise && frame_full && !rb_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q      <= '0;
      ldac_cap_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      if (sync_fall) begin
        ldac_cap_q <= ldac_n;
        pend_q     <= 1'b0;
      end
      if (frame_ok) begin
        if (!ldac_cap_q) dac_q  <= code_in;
        else             pend_q <= 1'b1;
      end else if (pend_q && ldac_fall) begin
        dac_q  <= code_in;
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                clamp_q <= 1'b0;
    else if (clr_fall)         clamp_q <= 1'b1;
    else if (clr_n && !ldac_n) clamp_q <= 1'b0;
  end

  // R6: an incomplete frame leaves the DAC register alone
  a_r6_partial_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && !frame_full) |=> $stable(dac_q));
  // R5: deferred mode holds the register at frame end
  a_r5_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && ldac_cap_q) |=> $stable(dac_q));
  // R4: immediate mode takes the code presented at frame end
  a_r4_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !ldac_cap_q) |=> (dac_q == $past(code_in)));
  // R9: clamp stays while clear is held low
  a_r9_clamp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_q && !clr_n) |=> clamp_q);
  // R9: clear never touches the DAC register
  a_r9_clear_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fall && !frame_ok && !ldac_fall) |=> $stable(dac_q));
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int RES = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           sdin,
  input  logic           sync_n,
  input  logic           ldac_n,
  input  logic           rben_n,
  input  logic           clr_n,
  input  logic           pd,
  output logic           sdo,
  output logic [RES-1:0] dac_code,
  output logic           out_clamp,
  output logic           pwr_down
);
  logic [CTL_W-1:0] ctl_now;
  logic [CTL_W-1:0] ctl_prev;
  logic sclk_fall, sync_fall, sync_rise, ldac_fall, rben_fall, clr_fall;
  logic [RES-1:0] shift_code;
  logic frame_full, rb_frame;

  assign ctl_now = {clr_n, rben_n, ldac_n, sync_n, sclk};

  sdac_sampler #(.W(CTL_W), .IDLE(CTL_IDLE)) u_sampler (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_now), .prev(ctl_prev)
  );

  assign sclk_fall = ctl_prev[I_SCLK] && !sclk;
  assign sync_fall = ctl_prev[I_SYNC] && !sync_n;
  assign sync_rise = !ctl_prev[I_SYNC] && sync_n;
  assign ldac_fall = ctl_prev[I_LDAC] && !ldac_n;
  assign rben_fall = ctl_prev[I_RBEN] && !rben_n;
  assign clr_fall  = ctl_prev[I_CLR] && !clr_n;

  sdac_shift #(.RES(RES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .sync_fall(sync_fall),
    .sync_low(!sync_n), .rben_fall(rben_fall), .sdin(sdin), .dac_q(dac_code),
    .shift_code(shift_code), .frame_full(frame_full), .rb_frame(rb_frame),
    .sdo(sdo)
  );

  sdac_dacreg #(.RES(RES)) u_dacreg (
    .clk(clk), .rst_n(rst_n), .sync_fall(sync_fall), .sync_rise(sync_rise),
    .ldac_n(ldac_n), .ldac_fall(ldac_fall), .clr_n(clr_n), .clr_fall(clr_fall),
    .frame_full(frame_full), .rb_frame(rb_frame), .code_in(shift_code),
    .dac_q(dac_code), .clamp_q(out_clamp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_down <= 1'b0;
    else        pwr_down <= pd;
  end

  // R10: power-down never disturbs the DAC register on its own
  a_r10_pd_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd) && !sync_rise && !ldac_fall) |=> $stable(dac_code));
endmodule

// File: tb/sdac_frontend_tb.sv
module sdac_frontend_tb;
  localparam int RES = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, sync_n = 1'b1, ldac_n = 1'b1;
  logic rben_n = 1'b1, clr_n = 1'b1, pd = 1'b0;
  logic sdo, out_clamp, pwr_down;
  logic [RES-1:0] dac_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [RES-1:0] exp_dac = '0;

  always #2 clk = ~clk;

  sdac_frontend #(.RES(RES)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .sync_n(sync_n),
    .ldac_n(ldac_n), .rben_n(rben_n), .clr_n(clr_n), .pd(pd), .sdo(sdo),
    .dac_code(dac_code), .out_clamp(out_clamp), .pwr_down(pwr_down)
  );

  function automatic logic [RES-1:0] code_of(input logic [15:0] w);
    return w[13 -: RES];
  endfunction

  function automatic logic [15:0] rb_of(input logic [RES-1:0] c);
    return 16'(c) << (14 - RES);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdin = b; sclk = 1'b1; idle(2);
    sclk = 1'b0; idle(2);
  endtask

  task automatic send_bits(input logic [31:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(d[i]);
  endtask

  task automatic frame(input logic [15:0] w, input logic ld, input int n);
    ldac_n = ld; idle(1);
    sync_n = 1'b0; idle(2);
    send_bits({16'h0, w}, n);
    sync_n = 1'b1; idle(2);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] w, wa, wb, rbw;
    void'($urandom(32'h5eed_1234));
    idle(3); rst_n = 1'b1; idle(2);
    // R1 reset state
    chk(dac_code == '0, "R1 code", int'(dac_code), 0);
    chk(!out_clamp && !pwr_down && !sdo, "R1 flags", {out_clamp, pwr_down, sdo}, 0);

    // R2 R3 R4 immediate with top bits set
    w = 16'hC5A3; frame(w, 1'b0, 16); exp_dac = code_of(w);
    chk(dac_code == exp_dac, "R3 ignored top bits", int'(dac_code), int'(exp_dac));

    // R2 R4 R5 random frames in both load modes
    for (int i = 0; i < 24; i++) begin
      logic mode;
      w = 16'($urandom); mode = 1'($urandom);
      frame(w, mode, 16);
      if (!mode) begin
        exp_dac = code_of(w);
        chk(dac_code == exp_dac, "R4 load at frame end", int'(dac_code), int'(exp_dac));
      end else begin
        idle(2);
        chk(dac_code == exp_dac, "R5 held after frame", int'(dac_code), int'(exp_dac));
        ldac_n = 1'b0; idle(2); ldac_n = 1'b1; idle(2);
        exp_dac = code_of(w);
        chk(dac_code == exp_dac, "R5 load on ldac", int'(dac_code), int'(exp_dac));
      end
    end

    // R6 partial frames
    for (int i = 0; i < 6; i++) begin
      int n;
      n = 1 + int'($urandom % 15);
      frame(16'($urandom), 1'b0, n);
      chk(dac_code == exp_dac, "R6 partial frame", int'(dac_code), int'(exp_dac));
    end

    // R5 pending load cancelled by a new frame
    frame(16'h1234, 1'b1, 16);
    frame(16'hFFFF, 1'b1, 5);
    ldac_n = 1'b0; idle(2); ldac_n = 1'b1; idle(2);
    chk(dac_code == exp_dac, "R5 cancel on new frame", int'(dac_code), int'(exp_dac));

    // R6 R8 long frame: chained output and last word kept
    wa = 16'hB36D; wb = 16'h2E91;
    ldac_n = 1'b0; idle(1); sync_n = 1'b0; idle(2);
    for (int k = 1; k <= 32; k++) begin
      pulse(k <= 16 ? wa[16 - k] : wb[32 - k]);
      if (k >= 16 && k <= 31)
        chk(sdo == wa[15 - (k - 16)], "R8 chained sdo", int'(sdo), int'(wa[15 - (k - 16)]));
    end
    sync_n = 1'b1; idle(2);
    exp_dac = code_of(wb);
    chk(dac_code == exp_dac, "R6 last 16 bits", int'(dac_code), int'(exp_dac));

    // R7 readback
    w = 16'($urandom); frame(w, 1'b0, 16); exp_dac = code_of(w);
    rbw = rb_of(exp_dac);
    sync_n = 1'b0; idle(2); rben_n = 1'b0; idle(2);
    for (int k = 0; k < 16; k++) begin
      pulse(1'b1);
      chk(sdo == rbw[15 - k], "R7 readback bit", int'(sdo), int'(rbw[15 - k]));
    end
    pulse(1'b1);
    sync_n = 1'b1; rben_n = 1'b1; idle(2);
    chk(dac_code == exp_dac, "R7 readback frame no load", int'(dac_code), int'(exp_dac));

    // R9 clear with ldac high
    ldac_n = 1'b1; idle(1);
    clr_n = 1'b0; idle(2);
    chk(out_clamp == 1'b1, "R9 clamp set", int'(out_clamp), 1);
    chk(dac_code == exp_dac, "R9 register kept", int'(dac_code), int'(exp_dac));
    clr_n = 1'b1; idle(2);
    chk(out_clamp == 1'b1, "R9 clamp waits for ldac", int'(out_clamp), 1);
    ldac_n = 1'b0; idle(2); ldac_n = 1'b1; idle(1);
    chk(out_clamp == 1'b0, "R9 clamp released by ldac", int'(out_clamp), 0);
    chk(dac_code == exp_dac, "R9 code after release", int'(dac_code), int'(exp_dac));
    // R9 clear with ldac held low
    ldac_n = 1'b0; idle(1);
    clr_n = 1'b0; idle(3);
    chk(out_clamp == 1'b1, "R9 clamp with ldac low", int'(out_clamp), 1);
    clr_n = 1'b1; idle(2);
    chk(out_clamp == 1'b0, "R9 immediate release", int'(out_clamp), 0);
    ldac_n = 1'b1; idle(1);

    // R10 power-down
    pd = 1'b1; idle(2);
    chk(pwr_down == 1'b1, "R10 flag set", int'(pwr_down), 1);
    chk(dac_code == exp_dac, "R10 register kept", int'(dac_code), int'(exp_dac));
    pd = 1'b0; idle(2);
    chk(pwr_down == 1'b0, "R10 flag cleared", int'(pwr_down), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule